// File: doc/BRIEF.md
# Double-Action Output Compare Channel

This block is one timer channel that turns a pair of compare values into a single pulse of variable width on one output pin. It watches an external free-running counter bus together with a counter-advance strobe. A leading-edge comparator and a trailing-edge comparator each hold an active compare value. When the counter reaches the leading value, the output takes the selected polarity. When it reaches the trailing value, the output goes back to the opposite level.

Software never writes the active compare values directly. It writes a shadow value for each comparator. That value moves into the active register on a later clock, and only while the update-hold control is low. Each such transfer arms its comparator for exactly one match. After the match the comparator disarms itself, so a new pulse needs a new pair of writes.

An event flag reports matches. A mode input selects whether the flag fires on both edges or on the trailing edge only. Two force strobes let software drive the output to either edge level at any time. A channel-enable input represents selecting this mode: while it is low the channel sits idle at the inactive level.

Top module: `dual_edge_pulse_channel`

## Requirements
- R1: While `chan_on` is low, both comparators are disarmed, pending transfers are dropped, `evt_flag` is 0 and `pulse_out` is the inverse of `out_pol`, all one clock after each edge. Compare values loaded before the channel is switched back on cause no match.
- R2: A comparator matches only when all three hold in the same cycle: it is armed, `cnt_adv` is 1 and `cnt_bus` equals its active value. After the match it disarms, so presenting the same value again, with or without `cnt_adv`, has no further effect.
- R3: A shadow write with `upd_hold` low transfers to the active register and arms the comparator on the next clock. With `upd_hold` high the transfer waits, and it happens on the first clock at which `upd_hold` is low.
- R4: A leading match sets `pulse_out` to `out_pol` and a trailing match sets it to the inverse of `out_pol`. The output changes at the clock edge that samples the match.
- R5: With `flag_on_lead` = 1, `evt_flag` sets on both leading and trailing matches. With `flag_on_lead` = 0 it sets on trailing matches only.
- R6: When both comparators match in the same cycle (equal active values), the channel acts on the trailing match alone: the output goes to the inverse of `out_pol` and the flag sets in either flag mode.
- R7: `force_lead` drives the output to `out_pol` and `force_trail` drives it to the inverse. A force overrides a match in the same cycle, and with both forces high the trailing level wins. Forces never change `evt_flag`, but a match in the same cycle still sets the flag.
- R8: `evt_flag` is sticky until a `flag_clr` pulse. If a set event and a clear fall in the same cycle, the flag stays 1.
- R9: Re-armed compare pairs keep producing pulses whether or not `evt_flag` has been cleared.
- R10: While `rst_n` is low, `pulse_out` and `evt_flag` are 0 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| chan_on | input | 1 | Channel in double-action mode; low means idle |
| wr_data | input | CNT_W | Data for shadow writes |
| lead_wr | input | 1 | Write `wr_data` into the leading shadow register |
| trail_wr | input | 1 | Write `wr_data` into the trailing shadow register |
| upd_hold | input | 1 | Holds shadow-to-active transfers while high |
| out_pol | input | 1 | Output level produced by a leading event |
| flag_on_lead | input | 1 | 1: flag on both edges, 0: flag on trailing edge only |
| force_lead | input | 1 | Force output to the leading level |
| force_trail | input | 1 | Force output to the trailing level |
| flag_clr | input | 1 | Clear the event flag |
| cnt_bus | input | CNT_W | External counter value |
| cnt_adv | input | 1 | Counter advanced this cycle |
| pulse_out | output | 1 | Output flip-flop |
| evt_flag | output | 1 | Sticky event flag |

## Verification
A flag clear and a flag set can fall in the same cycle. The bench provokes this by pulsing `flag_clr` in the very cycle the counter presents the trailing value with `cnt_adv` high, and it passes only if the flag reads 1 on the following cycle. A force strobe and a compare match can also coincide: `force_trail` is raised on the cycle of a leading match, and the output must take the trailing level while the flag still sets. A behavioural reference model, stepped on every clock, compares both outputs on every cycle of the run.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int unsigned NUM_CMP    = 2;
  localparam int unsigned IDX_LEAD   = 0;
  localparam int unsigned IDX_TRAIL  = 1;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LEAD  = 2'd1,
    EV_TRAIL = 2'd2
  } edge_ev_e;

  // Coincident matches collapse to the trailing event.
  function automatic edge_ev_e resolve_edge(input logic hit_lead, input logic hit_trail);
    if (hit_trail)     return EV_TRAIL;
    else if (hit_lead) return EV_LEAD;
    else               return EV_NONE;
  endfunction

endpackage

// File: rtl/dpc_shadow_xfer.sv
module dpc_shadow_xfer #(
  parameter int unsigned VAL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_on,
  input  logic             wr_stb,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             upd_hold,
  output logic [VAL_W-1:0] act_val,
  output logic             load_pulse
);

  logic [VAL_W-1:0] shadow_q;
  logic [VAL_W-1:0] act_q;
  logic             pend_q;
  logic             pend_d;

  assign load_pulse = pend_q & ~upd_hold & chan_on;
  assign act_val    = act_q;

  always_comb begin
    pend_d = pend_q;
    if (!chan_on)        pend_d = 1'b0;
    else if (wr_stb)     pend_d = 1'b1;
    else if (load_pulse) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_stb)     shadow_q <= wr_data;
      if (load_pulse) act_q    <= shadow_q;
      pend_q <= pend_d;
    end
  end

  // R3: no transfer reaches the active register while held
  assert_hold_blocks_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hold |=> $stable(act_val));

  // R3: an unheld write transfers on the following clock
  assert_xfer_next_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && chan_on) |=> (load_pulse || upd_hold || !chan_on));

endmodule

// File: rtl/dpc_cmp_unit.sv
module dpc_cmp_unit #(
  parameter int unsigned VAL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_on,
  input  logic             load,
  input  logic [VAL_W-1:0] ref_val,
  input  logic [VAL_W-1:0] cnt_bus,
  input  logic             cnt_adv,
  output logic             hit
);

  logic armed_q;
  logic armed_d;

  assign hit = armed_q & cnt_adv & (cnt_bus == ref_val);

  always_comb begin
    armed_d = armed_q;
    if (!chan_on)  armed_d = 1'b0;
    else if (load) armed_d = 1'b1;
    else if (hit)  armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R2: one-shot, a match without reload leaves the comparator disarmed
  assert_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load) |=> !hit);

  // R1: nothing matches one cycle into an idle channel
  assert_idle_disarms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_on && !load) |=> !hit);

endmodule

// File: rtl/dpc_out_flag.sv
module dpc_out_flag
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_on,
  input  logic out_pol,
  input  logic flag_on_lead,
  input  logic hit_lead,
  input  logic hit_trail,
  input  logic force_lead,
  input  logic force_trail,
  input  logic flag_clr,
  output logic pulse_out,
  output logic evt_flag
);

  logic     out_q, out_d;
  logic     flag_q, flag_d;
  edge_ev_e ev;

  assign ev = resolve_edge(hit_lead, hit_trail);

  always_comb begin
    out_d  = out_q;
    flag_d = flag_q;
    if (!chan_on) begin
      out_d  = ~out_pol;
      flag_d = 1'b0;
    end else begin
      case (ev)
        EV_LEAD:  out_d = out_pol;
        EV_TRAIL: out_d = ~out_pol;
        default:  out_d = out_q;
      endcase
      if (force_trail)     out_d = ~out_pol;
      else if (force_lead) out_d = out_pol;
      if (flag_clr) flag_d = 1'b0;
      if ((ev == EV_TRAIL) || ((ev == EV_LEAD) && flag_on_lead)) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      flag_q <= flag_d;
    end
  end

  assign pulse_out = out_q;
  assign evt_flag  = flag_q;

  // R4: trailing match gives the inverse polarity
  assert_trail_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && hit_trail && !force_lead && !force_trail) |=> (pulse_out == !$past(out_pol)));

  // R4: lone leading match gives the polarity level
  assert_lead_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && hit_lead && !hit_trail && !force_lead && !force_trail) |=> (pulse_out == $past(out_pol)));

  // R8: set beats clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && hit_trail) |=> evt_flag);

  // R5: trailing-only mode ignores leading matches for the flag
  assert_trail_only_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && !flag_on_lead && !hit_trail && !flag_clr) |=> $stable(evt_flag));

  // R7: forces leave the flag alone
  assert_force_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && (force_lead || force_trail) && !hit_lead && !hit_trail && !flag_clr) |=> $stable(evt_flag));

  // R1: idle channel clears the flag
  assert_idle_flag_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on |=> !evt_flag);

endmodule

// File: rtl/dual_edge_pulse_channel.sv
module dual_edge_pulse_channel
  import dpc_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_on,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             lead_wr,
  input  logic             trail_wr,
  input  logic             upd_hold,
  input  logic             out_pol,
  input  logic             flag_on_lead,
  input  logic             force_lead,
  input  logic             force_trail,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] cnt_bus,
  input  logic             cnt_adv,
  output logic             pulse_out,
  output logic             evt_flag
);

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic [NUM_CMP-1:0] wr_stb;
  logic [NUM_CMP-1:0] load;
  logic [NUM_CMP-1:0] hit;
  logic [CNT_W-1:0]   act_val [NUM_CMP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wr_stb[IDX_LEAD]  = lead_wr;
  assign wr_stb[IDX_TRAIL] = trail_wr;

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    dpc_shadow_xfer #(.VAL_W(CNT_W)) i_shadow (
      .clk        (clk),
      .rst_n      (core_rst_n),
      .chan_on    (chan_on),
      .wr_stb     (wr_stb[gi]),
      .wr_data    (wr_data),
      .upd_hold   (upd_hold),
      .act_val    (act_val[gi]),
      .load_pulse (load[gi])
    );
    dpc_cmp_unit #(.VAL_W(CNT_W)) i_cmp (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .chan_on (chan_on),
      .load    (load[gi]),
      .ref_val (act_val[gi]),
      .cnt_bus (cnt_bus),
      .cnt_adv (cnt_adv),
      .hit     (hit[gi])
    );
  end

  dpc_out_flag i_out (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .chan_on      (chan_on),
    .out_pol      (out_pol),
    .flag_on_lead (flag_on_lead),
    .hit_lead     (hit[IDX_LEAD]),
    .hit_trail    (hit[IDX_TRAIL]),
    .force_lead   (force_lead),
    .force_trail  (force_trail),
    .flag_clr     (flag_clr),
    .pulse_out    (pulse_out),
    .evt_flag     (evt_flag)
  );

  // R10: reset drives both outputs low at once
  always_comb begin
    if (!rst_n) assert_reset_outputs_R10: assert (pulse_out == 1'b0 && evt_flag == 1'b0 || $isunknown(core_rst_n));
  end

endmodule

// File: tb/test_dual_edge_pulse_channel.sv
module test_dual_edge_pulse_channel;

  localparam int CLK_P = 10;
  localparam int W     = 24;

  logic clk = 1'b0;
  logic rst_n, chan_on, lead_wr, trail_wr, upd_hold, out_pol, flag_on_lead;
  logic force_lead, force_trail, flag_clr, cnt_adv;
  logic [W-1:0] wr_data, cnt_bus;
  logic pulse_out, evt_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string phase = "R10";

  always #(CLK_P/2) clk = ~clk;

  dual_edge_pulse_channel #(.CNT_W(W)) i_dual_edge_pulse_channel (
    .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .wr_data(wr_data),
    .lead_wr(lead_wr), .trail_wr(trail_wr), .upd_hold(upd_hold), .out_pol(out_pol),
    .flag_on_lead(flag_on_lead), .force_lead(force_lead), .force_trail(force_trail),
    .flag_clr(flag_clr), .cnt_bus(cnt_bus), .cnt_adv(cnt_adv),
    .pulse_out(pulse_out), .evt_flag(evt_flag)
  );

  // Reference model state
  bit s1 = 0, s2 = 0;
  logic [W-1:0] m_a2 = '0, m_b2 = '0, m_a1 = '0, m_b1 = '0;
  bit m_pa = 0, m_pb = 0, m_arma = 0, m_armb = 0, m_out = 0, m_flag = 0;

  always @(posedge clk) begin
    bit live, ha, hb, la, lb, ea, setf;
    live = s2;
    if (!rst_n) begin
      s1 = 0; s2 = 0;
    end else begin
      s2 = s1; s1 = 1;
    end
    if (!rst_n || !live) begin
      m_a2 = '0; m_b2 = '0; m_a1 = '0; m_b1 = '0;
      m_pa = 0; m_pb = 0; m_arma = 0; m_armb = 0; m_out = 0; m_flag = 0;
    end else begin
      ha = m_arma && cnt_adv && (cnt_bus == m_a1);
      hb = m_armb && cnt_adv && (cnt_bus == m_b1);
      la = m_pa && !upd_hold && chan_on;
      lb = m_pb && !upd_hold && chan_on;
      if (la) m_a1 = m_a2;
      if (lb) m_b1 = m_b2;
      if (lead_wr)  m_a2 = wr_data;
      if (trail_wr) m_b2 = wr_data;
      if (!chan_on) begin
        m_pa = 0; m_pb = 0; m_arma = 0; m_armb = 0;
        m_out = !out_pol; m_flag = 0;
      end else begin
        m_pa = lead_wr ? 1 : (la ? 0 : m_pa);
        m_pb = trail_wr ? 1 : (lb ? 0 : m_pb);
        m_arma = la ? 1 : (ha ? 0 : m_arma);
        m_armb = lb ? 1 : (hb ? 0 : m_armb);
        ea = ha && !hb;
        if (force_trail)     m_out = !out_pol;
        else if (force_lead) m_out = out_pol;
        else if (hb)         m_out = !out_pol;
        else if (ea)         m_out = out_pol;
        setf = hb || (ea && flag_on_lead);
        if (setf)          m_flag = 1;
        else if (flag_clr) m_flag = 0;
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      n_chk++;
      if (pulse_out !== m_out || evt_flag !== m_flag) begin
        n_fail++;
        $display("FAIL model %s: actual out=%b flag=%b expected out=%b flag=%b",
                 phase, pulse_out, evt_flag, m_out, m_flag);
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    cnt_adv = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_cnt(input logic [W-1:0] v, input logic a);
    cnt_bus = v; cnt_adv = a;
    @(negedge clk);
    cnt_adv = 1'b0;
  endtask

  task automatic wr_pair(input logic [W-1:0] a, input logic [W-1:0] b);
    wr_data = a; lead_wr = 1'b1;
    @(negedge clk);
    lead_wr = 1'b0; wr_data = b; trail_wr = 1'b1;
    @(negedge clk);
    trail_wr = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chan_on = 1'b0; wr_data = '0; lead_wr = 0; trail_wr = 0;
    upd_hold = 0; out_pol = 1'b1; flag_on_lead = 0; force_lead = 0;
    force_trail = 0; flag_clr = 0; cnt_bus = '0; cnt_adv = 0;
    #1;
    chk("R10 reset out", pulse_out, 1'b0);
    chk("R10 reset flag", evt_flag, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    phase = "R1";
    chk("R1 idle level", pulse_out, 1'b0);
    chk("R1 idle flag", evt_flag, 1'b0);

    // Basic pulse, trailing-only flag
    phase = "R4";
    chan_on = 1'b1; idle(2);
    wr_pair(24'd10, 24'd20); idle(1);
    for (int v = 0; v <= 25; v++) begin
      drive_cnt(v[W-1:0], 1'b1);
      if (v == 10) begin
        chk("R4 lead level", pulse_out, 1'b1);
        chk("R5 no flag on lead", evt_flag, 1'b0);
      end
      if (v == 20) begin
        chk("R4 trail level", pulse_out, 1'b0);
        chk("R5 flag on trail", evt_flag, 1'b1);
      end
    end

    // One-shot and advance qualification
    phase = "R2";
    drive_cnt(24'd10, 1'b1);
    chk("R2 no rematch lead", pulse_out, 1'b0);
    clr_flag();
    chk("R8 clear", evt_flag, 1'b0);
    wr_pair(24'd30, 24'd40); idle(1);
    repeat (3) drive_cnt(24'd30, 1'b0);
    chk("R2 no match without advance", pulse_out, 1'b0);
    drive_cnt(24'd30, 1'b1);
    chk("R2 match with advance", pulse_out, 1'b1);
    drive_cnt(24'd40, 1'b1);
    drive_cnt(24'd40, 1'b1);
    chk("R2 trail once", pulse_out, 1'b0);

    // Set and clear in the same cycle
    phase = "R8";
    clr_flag();
    wr_pair(24'd50, 24'd60); idle(1);
    drive_cnt(24'd50, 1'b1);
    flag_clr = 1'b1;
    drive_cnt(24'd60, 1'b1);
    flag_clr = 1'b0;
    chk("R8 set wins", evt_flag, 1'b1);
    clr_flag();
    chk("R8 clear after", evt_flag, 1'b0);

    // Flag on both edges
    phase = "R5";
    flag_on_lead = 1'b1;
    wr_pair(24'd70, 24'd80); idle(1);
    drive_cnt(24'd70, 1'b1);
    chk("R5 flag on lead", evt_flag, 1'b1);
    clr_flag();
    drive_cnt(24'd80, 1'b1);
    chk("R5 flag on trail both mode", evt_flag, 1'b1);

    // Pulses continue while flag stays set
    phase = "R9";
    flag_on_lead = 1'b0;
    wr_pair(24'd90, 24'd100); idle(1);
    drive_cnt(24'd90, 1'b1);
    chk("R9 lead with flag set", pulse_out, 1'b1);
    drive_cnt(24'd100, 1'b1);
    chk("R9 trail with flag set", pulse_out, 1'b0);

    // Equal values
    phase = "R6";
    clr_flag();
    wr_pair(24'd110, 24'd110); idle(1);
    force_lead = 1'b1; idle(1); force_lead = 1'b0;
    chk("R7 force lead level", pulse_out, 1'b1);
    chk("R7 force keeps flag", evt_flag, 1'b0);
    drive_cnt(24'd110, 1'b1);
    chk("R6 equal gives trail level", pulse_out, 1'b0);
    chk("R6 equal sets flag", evt_flag, 1'b1);

    // Force against match
    phase = "R7";
    flag_on_lead = 1'b1;
    clr_flag();
    wr_pair(24'd120, 24'd130); idle(1);
    force_trail = 1'b1;
    drive_cnt(24'd120, 1'b1);
    force_trail = 1'b0;
    chk("R7 force beats match", pulse_out, 1'b0);
    chk("R7 match still flags", evt_flag, 1'b1);
    force_lead = 1'b1; idle(1); force_lead = 1'b0;
    force_lead = 1'b1; force_trail = 1'b1; idle(1);
    force_lead = 1'b0; force_trail = 1'b0;
    chk("R7 both forces trail level", pulse_out, 1'b0);
    drive_cnt(24'd130, 1'b1);
    chk("R7 trail after forces", pulse_out, 1'b0);

    // Update hold
    phase = "R3";
    flag_on_lead = 1'b0;
    clr_flag();
    upd_hold = 1'b1;
    wr_pair(24'd140, 24'd150); idle(2);
    drive_cnt(24'd140, 1'b1);
    chk("R3 held transfer no match", pulse_out, 1'b0);
    upd_hold = 1'b0; idle(1);
    drive_cnt(24'd140, 1'b1);
    chk("R3 released transfer matches", pulse_out, 1'b1);
    drive_cnt(24'd150, 1'b1);
    chk("R3 trail after release", pulse_out, 1'b0);

    // Leaving and re-entering the mode
    phase = "R1";
    wr_pair(24'd160, 24'd170); idle(1);
    chan_on = 1'b0; out_pol = 1'b0; idle(1);
    chk("R1 off level", pulse_out, 1'b1);
    chk("R1 off flag", evt_flag, 1'b0);
    chan_on = 1'b1; idle(1);
    drive_cnt(24'd160, 1'b1);
    chk("R1 disarmed on entry", pulse_out, 1'b1);
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule